// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Capture

This block controls 128 general-purpose pins grouped into four banks of 32. Software reaches it through a simple word-addressed register bus. For each bank it can set the pin directions, drive output pins, read pin levels, arm edge detection on input pins and collect captured edges in a sticky status word. Each bank also holds two alternate-function words, which are plain storage for use elsewhere in the chip.

Output values are never written directly. Software changes them through a set register (write ones to raise bits) and a clear register (write ones to lower bits), so no read-modify-write is needed. Input pins arrive already synchronised. The block compares each pin with its value on the previous clock to find rising and falling edges. Captured edges are grouped onto three interrupt lines. A wake request pulses when any pin in a fixed wake set changes while it is an input.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset, every register reads 0, every pin is an input, `pin_out` is all zero, and all three interrupts and `wake_req` are low.
- R2: In each bank, the level register returns the output latch on pins whose direction bit is 1 and the live `pin_in` value on pins whose direction bit is 0.
- R3: A write to a set register ORs the data into that bank's output latch. A write to a clear register lowers the latch bits where the data is 1. A read of either register returns 0.
- R4: `pin_out` equals the output latch ANDed with the direction bits. It changes at the clock edge that accepts a direction, set or clear write, and at no other edge.
- R5: A 0-to-1 change of an input pin between two clocks sets its status bit if its rising-enable bit is 1. A 1-to-0 change sets it if its falling-enable bit is 1. Pins whose direction bit is 1 never set status.
- R6: Writing the status register clears each bit written as 1. A capture and a clear of the same bit in the same cycle leave the bit set.
- R7: `irq_pin0` follows status bit 0 of bank 0 and `irq_pin1` follows status bit 1 of bank 0. `irq_rest` is the OR of bank 0 status bits 2 to 31 and every status bit of banks 1 to 3. All three update at the same edge as the status.
- R8: The eight alternate-function words store and return whatever is written to them. The low and high words of bank b sit at 0x054+8b and 0x058+8b.
- R9: `wake_req` is high for the cycle after an edge at which some input pin differs from its previous sample, provided that pin is in its bank's wake mask. The masks for banks 0 to 3 are 0x8003FE1B, 0x002001FC, 0xEC080000 and 0x0012007F.
- R10: Byte offsets are decoded with address bits 1:0 ignored. In banks 0 to 2 the registers are level 0x000+4b, direction 0x00C+4b, set 0x018+4b, clear 0x024+4b, rising 0x030+4b, falling 0x03C+4b and status 0x048+4b. Bank 3 uses the bank 0 offsets plus 0x100. Offsets of 0x200 and above, and unmapped offsets, read 0 and ignore writes.
- R11: `bus_rdata` holds the read result in the cycle after `bus_rd` is sampled high, and is 0 after a cycle without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 128 | Synchronised pin levels, bank b at bits 32b+31:32b |
| pin_out | output | 128 | Driven pin values, same bit layout |
| irq_pin0 | output | 1 | Bank 0 pin 0 edge interrupt |
| irq_pin1 | output | 1 | Bank 0 pin 1 edge interrupt |
| irq_rest | output | 1 | Any other captured edge |
| wake_req | output | 1 | One-cycle wake pulse |

## Verification
Assertions check on every cycle that output pins never set status, that status bits drop only when a status write asks for it, and that `pin_out` stays free of input pins and moves only after a direction, set or clear write. They also check that the interrupt lines agree with the stored bank 0 status, that a wake pulse always follows a real pin change, and that set, clear and out-of-range reads return zero. The bench's scenarios cover the rest: the exact address map including the bank 3 window, readback of the alternate-function words, the live level mux, the set-over-clear priority of status, and the wake mask. A cycle-accurate model in the bench checks all outputs against these requirements under random traffic.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  localparam int NUM_BANKS = 4;

  typedef enum logic [3:0] {
    RK_NONE, RK_LEVEL, RK_DIR, RK_SET, RK_CLR,
    RK_RISE, RK_FALL, RK_STAT, RK_ALTLO, RK_ALTHI
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e  kind;
    logic [1:0] bank;
  } reg_sel_t;

  // Fixed wake-capable pins per bank
  function automatic logic [31:0] wake_mask(input int b);
    case (b)
      0:       return 32'h8003_FE1B;
      1:       return 32'h0020_01FC;
      2:       return 32'hEC08_0000;
      default: return 32'h0012_007F;
    endcase
  endfunction

  // Group index inside the low window -> register kind
  function automatic reg_kind_e group_kind(input logic [5:0] g);
    case (g)
      6'd0:    return RK_LEVEL;
      6'd1:    return RK_DIR;
      6'd2:    return RK_SET;
      6'd3:    return RK_CLR;
      6'd4:    return RK_RISE;
      6'd5:    return RK_FALL;
      6'd6:    return RK_STAT;
      default: return RK_NONE;
    endcase
  endfunction

endpackage

// File: rtl/gpio_regmap.sv
module gpio_regmap
  import gpio_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_t          sel
);

  localparam int HI_W = ADDR_W - 9;

  logic [5:0]      word;
  logic [5:0]      grp;
  logic [5:0]      rem;
  logic [5:0]      afi;
  logic [HI_W-1:0] hi_bits;
  logic [1:0]      unused_lsb;

  assign word       = addr[7:2];
  assign hi_bits    = addr[ADDR_W-1:9];
  assign unused_lsb = addr[1:0];
  assign grp        = word / 6'd3;
  assign rem        = word % 6'd3;
  assign afi        = word - 6'd21;

  always_comb begin
    sel.kind = RK_NONE;
    sel.bank = 2'd0;
    if (hi_bits == '0) begin
      if (!addr[8]) begin
        if (word < 6'd21) begin
          sel.kind = group_kind(grp);
          sel.bank = rem[1:0];
        end else if (word < 6'd29) begin
          sel.kind = afi[0] ? RK_ALTHI : RK_ALTLO;
          sel.bank = afi[2:1];
        end
      end else if (rem == 6'd0 && word <= 6'd18) begin
        sel.kind = group_kind(grp);
        sel.bank = 2'd3;
      end
    end
  end

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank #(
  parameter int               PIN_W     = 32,
  parameter logic [PIN_W-1:0] WAKE_MASK = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_dir,
  input  logic             wr_set,
  input  logic             wr_clr,
  input  logic             wr_rise,
  input  logic             wr_fall,
  input  logic             wr_stat,
  input  logic             wr_altlo,
  input  logic             wr_althi,
  input  logic [PIN_W-1:0] wdata,
  input  logic [PIN_W-1:0] pin_in,
  output logic [PIN_W-1:0] rd_level,
  output logic [PIN_W-1:0] rd_dir,
  output logic [PIN_W-1:0] rd_rise,
  output logic [PIN_W-1:0] rd_fall,
  output logic [PIN_W-1:0] rd_stat,
  output logic [PIN_W-1:0] rd_altlo,
  output logic [PIN_W-1:0] rd_althi,
  output logic [PIN_W-1:0] stat_next,
  output logic [PIN_W-1:0] pin_out,
  output logic             wake
);

  logic [PIN_W-1:0] dir_q, olat_q, rise_q, fall_q, stat_q;
  logic [PIN_W-1:0] altlo_q, althi_q, prev_q, pout_q;
  logic [PIN_W-1:0] dir_d, olat_d, stat_d, cap, chg;
  logic             wake_q;

  always_comb begin
    dir_d  = wr_dir ? wdata : dir_q;
    olat_d = olat_q;
    if (wr_set) olat_d = olat_d | wdata;
    if (wr_clr) olat_d = olat_d & ~wdata;
    chg    = (pin_in ^ prev_q) & ~dir_q;
    cap    = ((pin_in & ~prev_q & rise_q) | (~pin_in & prev_q & fall_q)) & ~dir_q;
    stat_d = (stat_q & ~(wr_stat ? wdata : '0)) | cap;
  end

  // previous sample tracks the pins through reset too
  always_ff @(posedge clk) prev_q <= pin_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q   <= '0;
      olat_q  <= '0;
      rise_q  <= '0;
      fall_q  <= '0;
      stat_q  <= '0;
      altlo_q <= '0;
      althi_q <= '0;
      pout_q  <= '0;
      wake_q  <= 1'b0;
    end else begin
      dir_q   <= dir_d;
      olat_q  <= olat_d;
      stat_q  <= stat_d;
      pout_q  <= olat_d & dir_d;
      wake_q  <= |(chg & WAKE_MASK);
      if (wr_rise)  rise_q  <= wdata;
      if (wr_fall)  fall_q  <= wdata;
      if (wr_altlo) altlo_q <= wdata;
      if (wr_althi) althi_q <= wdata;
    end
  end

  assign rd_level  = (olat_q & dir_q) | (pin_in & ~dir_q);
  assign rd_dir    = dir_q;
  assign rd_rise   = rise_q;
  assign rd_fall   = fall_q;
  assign rd_stat   = stat_q;
  assign rd_altlo  = altlo_q;
  assign rd_althi  = althi_q;
  assign stat_next = stat_d;
  assign pin_out   = pout_q;
  assign wake      = wake_q;

  // R4
  out_only_dir_chk: assert property (@(posedge clk) disable iff (rst)
    (pout_q & ~dir_q) == '0);

  // R4
  out_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_dir || wr_set || wr_clr) |-> $stable(pout_q));

  // R5
  no_out_capture_chk: assert property (@(posedge clk) disable iff (rst)
    ((stat_q & ~$past(stat_q)) & $past(dir_q)) == '0);

  // R6
  stat_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (($past(stat_q) & ~stat_q) & ~($past(wr_stat) ? $past(wdata) : '0)) == '0);

  // R9
  wake_cause_chk: assert property (@(posedge clk) disable iff (rst)
    wake_q |-> ($past(pin_in) != $past(pin_in, 2)));

endmodule

// File: rtl/gpio_irq_merge.sv
module gpio_irq_merge #(
  parameter int NUM_BANKS = 4,
  parameter int PIN_W     = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_BANKS*PIN_W-1:0] stat_flat,
  output logic                       irq_a,
  output logic                       irq_b,
  output logic                       irq_c
);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_a <= 1'b0;
      irq_b <= 1'b0;
      irq_c <= 1'b0;
    end else begin
      irq_a <= stat_flat[0];
      irq_b <= stat_flat[1];
      irq_c <= |stat_flat[NUM_BANKS*PIN_W-1:2];
    end
  end

endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_pkg::*;
#(
  parameter int PIN_W  = 32,
  parameter int ADDR_W = 12
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       bus_wr,
  input  logic                       bus_rd,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [PIN_W-1:0]           bus_wdata,
  output logic [PIN_W-1:0]           bus_rdata,
  input  logic [NUM_BANKS*PIN_W-1:0] pin_in,
  output logic [NUM_BANKS*PIN_W-1:0] pin_out,
  output logic                       irq_pin0,
  output logic                       irq_pin1,
  output logic                       irq_rest,
  output logic                       wake_req
);

  localparam int ALL_W = NUM_BANKS * PIN_W;

  reg_sel_t sel;
  logic [PIN_W-1:0] b_level [NUM_BANKS];
  logic [PIN_W-1:0] b_dir   [NUM_BANKS];
  logic [PIN_W-1:0] b_rise  [NUM_BANKS];
  logic [PIN_W-1:0] b_fall  [NUM_BANKS];
  logic [PIN_W-1:0] b_stat  [NUM_BANKS];
  logic [PIN_W-1:0] b_altlo [NUM_BANKS];
  logic [PIN_W-1:0] b_althi [NUM_BANKS];
  logic [NUM_BANKS-1:0] b_wake;
  logic [ALL_W-1:0] stat_flat;
  logic [PIN_W-1:0] rd_mux;
  logic [PIN_W-1:0] rdata_q;

  gpio_regmap #(.ADDR_W(ADDR_W)) u_map (
    .addr (bus_addr),
    .sel  (sel)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = bus_wr && (sel.bank == 2'(b));

    gpio_bank #(
      .PIN_W     (PIN_W),
      .WAKE_MASK (PIN_W'(wake_mask(b)))
    ) u_bank (
      .clk       (clk),
      .rst       (rst),
      .wr_dir    (hit && sel.kind == RK_DIR),
      .wr_set    (hit && sel.kind == RK_SET),
      .wr_clr    (hit && sel.kind == RK_CLR),
      .wr_rise   (hit && sel.kind == RK_RISE),
      .wr_fall   (hit && sel.kind == RK_FALL),
      .wr_stat   (hit && sel.kind == RK_STAT),
      .wr_altlo  (hit && sel.kind == RK_ALTLO),
      .wr_althi  (hit && sel.kind == RK_ALTHI),
      .wdata     (bus_wdata),
      .pin_in    (pin_in[b*PIN_W +: PIN_W]),
      .rd_level  (b_level[b]),
      .rd_dir    (b_dir[b]),
      .rd_rise   (b_rise[b]),
      .rd_fall   (b_fall[b]),
      .rd_stat   (b_stat[b]),
      .rd_altlo  (b_altlo[b]),
      .rd_althi  (b_althi[b]),
      .stat_next (stat_flat[b*PIN_W +: PIN_W]),
      .pin_out   (pin_out[b*PIN_W +: PIN_W]),
      .wake      (b_wake[b])
    );
  end

  gpio_irq_merge #(.NUM_BANKS(NUM_BANKS), .PIN_W(PIN_W)) u_irq (
    .clk       (clk),
    .rst       (rst),
    .stat_flat (stat_flat),
    .irq_a     (irq_pin0),
    .irq_b     (irq_pin1),
    .irq_c     (irq_rest)
  );

  always_comb begin
    case (sel.kind)
      RK_LEVEL: rd_mux = b_level[sel.bank];
      RK_DIR:   rd_mux = b_dir[sel.bank];
      RK_RISE:  rd_mux = b_rise[sel.bank];
      RK_FALL:  rd_mux = b_fall[sel.bank];
      RK_STAT:  rd_mux = b_stat[sel.bank];
      RK_ALTLO: rd_mux = b_altlo[sel.bank];
      RK_ALTHI: rd_mux = b_althi[sel.bank];
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= bus_rd ? rd_mux : '0;
  end

  assign bus_rdata = rdata_q;
  assign wake_req  = |b_wake;

  // R7
  irq0_track_chk: assert property (@(posedge clk) disable iff (rst)
    irq_pin0 == b_stat[0][0]);

  // R7
  irq1_track_chk: assert property (@(posedge clk) disable iff (rst)
    irq_pin1 == b_stat[0][1]);

  // R3
  setclr_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    bus_rd && (sel.kind == RK_SET || sel.kind == RK_CLR) |=> bus_rdata == '0);

  // R10
  high_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    bus_rd && (bus_addr[ADDR_W-1:9] != '0) |=> bus_rdata == '0);

  // R11
  idle_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> bus_rdata == '0);

endmodule

// File: tb/gpio_bank_ctrl_tb.sv
module gpio_bank_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NB = 4;
  localparam int PW = 32;
  localparam int OFFS [7] = '{'h00, 'h0C, 'h18, 'h24, 'h30, 'h3C, 'h48};
  localparam logic [31:0] WMASK [4] = '{32'h8003FE1B, 32'h002001FC,
                                        32'hEC080000, 32'h0012007F};

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         bus_wr = 1'b0;
  logic         bus_rd = 1'b0;
  logic [11:0]  bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic [127:0] pin_in = '0;
  logic [127:0] pin_out;
  logic         irq_pin0, irq_pin1, irq_rest, wake_req;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_bank_ctrl u_dut (
    .clk (clk), .rst (rst), .bus_wr (bus_wr), .bus_rd (bus_rd),
    .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
    .pin_in (pin_in), .pin_out (pin_out), .irq_pin0 (irq_pin0),
    .irq_pin1 (irq_pin1), .irq_rest (irq_rest), .wake_req (wake_req)
  );

  // reference state
  logic [31:0] m_dir [NB], m_olat [NB], m_rise [NB], m_fall [NB];
  logic [31:0] m_stat [NB], m_prev [NB], m_alt [2*NB];
  logic [31:0] m_rd;
  logic        m_wake, m_i0, m_i1, m_ix;

  // returns kind*8+bank: kinds 0..6 bank regs, 7 alt low, 8 alt high; -1 none
  function automatic int mkind(input logic [11:0] a);
    logic [11:0] w;
    w = {a[11:2], 2'b00};
    for (int b = 0; b < NB; b++) begin
      for (int k = 0; k < 7; k++) begin
        if (int'(w) == ((b == 3) ? 'h100 : 4*b) + OFFS[k]) return k*8 + b;
      end
    end
    for (int i = 0; i < 2*NB; i++)
      if (int'(w) == 'h54 + 4*i) return (7 + i%2)*8 + i/2;
    return -1;
  endfunction

  function automatic logic [31:0] mread(input logic [11:0] a);
    int m, b;
    m = mkind(a);
    if (m < 0) return '0;
    b = m % 8;
    case (m / 8)
      0: return (m_olat[b] & m_dir[b]) | (pin_in[b*PW +: PW] & ~m_dir[b]);
      1: return m_dir[b];
      4: return m_rise[b];
      5: return m_fall[b];
      6: return m_stat[b];
      7: return m_alt[2*b];
      8: return m_alt[2*b+1];
      default: return '0;
    endcase
  endfunction

  function automatic logic [127:0] mpout();
    logic [127:0] v;
    for (int b = 0; b < NB; b++) v[b*PW +: PW] = m_olat[b] & m_dir[b];
    return v;
  endfunction

  always @(posedge clk) begin
    logic [31:0] cap [NB];
    logic [31:0] p, ch;
    int m, b;
    if (rst) begin
      for (int i = 0; i < NB; i++) begin
        m_dir[i] = '0; m_olat[i] = '0; m_rise[i] = '0; m_fall[i] = '0;
        m_stat[i] = '0; m_prev[i] = pin_in[i*PW +: PW];
        m_alt[2*i] = '0; m_alt[2*i+1] = '0;
      end
      m_rd = '0; m_wake = 1'b0; m_i0 = 1'b0; m_i1 = 1'b0; m_ix = 1'b0;
    end else begin
      m_rd = bus_rd ? mread(bus_addr) : '0;
      m_wake = 1'b0;
      for (int i = 0; i < NB; i++) begin
        p = pin_in[i*PW +: PW];
        ch = (p ^ m_prev[i]) & ~m_dir[i];
        if ((ch & WMASK[i]) != 0) m_wake = 1'b1;
        cap[i] = ((p & ~m_prev[i] & m_rise[i]) | (~p & m_prev[i] & m_fall[i])) & ~m_dir[i];
        m_prev[i] = p;
      end
      if (bus_wr) begin
        m = mkind(bus_addr);
        if (m >= 0) begin
          b = m % 8;
          case (m / 8)
            1: m_dir[b] = bus_wdata;
            2: m_olat[b] = m_olat[b] | bus_wdata;
            3: m_olat[b] = m_olat[b] & ~bus_wdata;
            4: m_rise[b] = bus_wdata;
            5: m_fall[b] = bus_wdata;
            6: m_stat[b] = m_stat[b] & ~bus_wdata;
            7: m_alt[2*b] = bus_wdata;
            8: m_alt[2*b+1] = bus_wdata;
            default: ;
          endcase
        end
      end
      for (int i = 0; i < NB; i++) m_stat[i] = m_stat[i] | cap[i];
      m_i0 = m_stat[0][0];
      m_i1 = m_stat[0][1];
      m_ix = ((m_stat[0] & ~32'h3) | m_stat[1] | m_stat[2] | m_stat[3]) != 0;
    end
  end

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // continuous comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R4 pin_out", pin_out, mpout());
      check("R11 rdata", {96'b0, bus_rdata}, {96'b0, m_rd});
      check("R9 wake", {127'b0, wake_req}, {127'b0, m_wake});
      check("R7 irq", {125'b0, irq_pin0, irq_pin1, irq_rest},
            {125'b0, m_i0, m_i1, m_ix});
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pins(input logic [127:0] v);
    @(negedge clk);
    pin_in = v;
    @(negedge clk);
  endtask

  function automatic logic [11:0] rand_addr();
    int k;
    k = int'($urandom % 40);
    if (k < 28) return 12'(((k/7 == 3) ? 'h100 : 4*(k/7)) + OFFS[k%7]);
    if (k < 36) return 12'('h54 + 4*(k-28));
    return 12'($urandom);
  endfunction

  initial begin
    #(CLK_PERIOD*200000);
    if (!done) begin
      done = 1'b1;
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(12'h000, v); check("R1 level after reset", {96'b0, v}, '0);
    rd(12'h148, v); check("R1 status after reset", {96'b0, v}, '0);
    check("R1 pin_out after reset", pin_out, '0);

    // R3 / R4 set and clear
    wr(12'h00C, 32'h0000_00FF);
    wr(12'h018, 32'h0000_0F0F);
    check("R4 pin_out after set", pin_out, 128'h0F);
    rd(12'h018, v); check("R3 set reads 0", {96'b0, v}, '0);
    wr(12'h024, 32'h0000_0001);
    check("R3 pin_out after clear", pin_out, 128'h0E);
    rd(12'h024, v); check("R3 clear reads 0", {96'b0, v}, '0);

    // R2 level mux
    pins(128'hA5A5_00F0);
    rd(12'h000, v); check("R2 level mux", {96'b0, v}, 128'hA5A5_000E);
    wr(12'h00C, 32'h0);
    check("R4 dir cleared drops outputs", pin_out, '0);
    pins('0);

    // R5 edge capture, bank 1
    wr(12'h034, 32'h0000_0030);
    wr(12'h010, 32'h0000_0020);
    pins(128'h0030 << 32);
    rd(12'h04C, v); check("R5 rise captured, output pin ignored", {96'b0, v}, 128'h10);
    check("R7 irq_rest from bank 1", {127'b0, irq_rest}, 128'h1);

    // R6 clear, then capture wins over clear
    wr(12'h04C, 32'h0000_0010);
    check("R6 w1c clears irq_rest", {127'b0, irq_rest}, '0);
    wr(12'h040, 32'h0000_0010);
    @(negedge clk);
    pin_in = '0; bus_wr = 1'b1; bus_addr = 12'h04C; bus_wdata = 32'h10;
    @(negedge clk);
    bus_wr = 1'b0;
    rd(12'h04C, v); check("R6 capture beats clear", {96'b0, v}, 128'h10);
    wr(12'h04C, 32'hFFFF_FFFF);

    // R7 dedicated lines
    wr(12'h030, 32'h0000_0003);
    pins(128'h1);
    check("R7 irq_pin0", {126'b0, irq_pin0, irq_pin1}, 128'h2);
    pins(128'h3);
    check("R7 irq_pin1", {125'b0, irq_pin0, irq_pin1, irq_rest}, 128'h6);
    wr(12'h048, 32'h3);
    check("R7 lines cleared", {125'b0, irq_pin0, irq_pin1, irq_rest}, '0);

    // R9 wake mask: bank 0 bit 2 not in mask, bit 3 is
    @(negedge clk); pin_in = pin_in ^ 128'h4;
    @(negedge clk); check("R9 non-wake pin", {127'b0, wake_req}, '0);
    @(negedge clk); pin_in = pin_in ^ 128'h8;
    @(negedge clk); check("R9 wake pin", {127'b0, wake_req}, 128'h1);

    // R8 alternate-function storage
    wr(12'h058, 32'hDEAD_BEEF);
    wr(12'h06C, 32'h1234_5678);
    rd(12'h058, v); check("R8 bank0 high", {96'b0, v}, 128'hDEAD_BEEF);
    rd(12'h06C, v); check("R8 bank3 low", {96'b0, v}, 128'h1234_5678);
    rd(12'h054, v); check("R8 bank0 low untouched", {96'b0, v}, '0);

    // R10 bank 3 window and ignored ranges
    wr(12'h10C, 32'hFFFF_0000);
    wr(12'h11B, 32'h0003_0000);
    check("R10 bank3 set", pin_out, 128'h3 << 112);
    wr(12'h20C, 32'hFFFF_FFFF);
    rd(12'h00C, v); check("R10 high write ignored", {96'b0, v}, '0);
    rd(12'h20C, v); check("R10 high read zero", {96'b0, v}, '0);
    rd(12'h104, v); check("R10 unmapped read zero", {96'b0, v}, '0);
    @(negedge clk); check("R11 idle rdata zero", {96'b0, bus_rdata}, '0);

    // random traffic checked by the model
    for (int it = 0; it < 4000; it++) begin
      @(negedge clk);
      for (int b = 0; b < NB; b++)
        pin_in[b*PW +: PW] = pin_in[b*PW +: PW] ^ ($urandom & $urandom & $urandom);
      bus_rd = 1'b0; bus_wr = 1'b0;
      case ($urandom % 3)
        0: ;
        1: begin bus_rd = 1'b1; bus_addr = rand_addr(); end
        default: begin bus_wr = 1'b1; bus_addr = rand_addr(); bus_wdata = $urandom; end
      endcase
    end
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0;
    @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule